// File: doc/BRIEF.md
# Indirect Dword Register Window

This block is an 8-byte window placed inside a configuration space. Through it, software reaches a larger controller register file one dword at a time. The window holds two fields. The first is a one-byte index register, in byte 2 of the window's first dword. The second is a 32-bit data field that fills the window's second dword. Software writes the index first. It then reads or writes the data field, which stands for the register at byte address index×4 of the backing file.

The data field is a local copy. The block keeps that copy coherent through a two-state controller:

- **ST_REFRESH** loads the copy from the backing file at the current index.
- **ST_IDLE** holds the copy.

The controller moves as follows:

- Reset enters ST_REFRESH, so the copy is valid one cycle after reset.
- Any configuration write that touches the window with at least one byte enable goes to ST_REFRESH, from either state.
- Every other cycle goes to ST_IDLE.

A write to the data field is forwarded in the same cycle to the backing file. That write carries the full 32-bit merged value. On the next edge the copy is reloaded from the backing register, so a read shows whatever masking the backing register applies. Indexes whose byte address lies at or beyond the file size are never written, and they read as zero.

Top module: `iw_dword_window`

## Requirements
- R1: After reset the index is 0, and one cycle after reset is released the data field equals backing register 0. During reset no backing write is issued.
- R2: The index byte (window dword 0, bits 23:16) is fully writable. Bits 31:24 (status) and bits 15:0 of that dword always read as zero, even when written.
- R3: In the same cycle as a configuration write that touches the data dword, the backing write strobe is high, the backing address is index×4, and the backing data is the merged 32-bit value.
- R4: In a partial write to the data field, enabled bytes take the new data and disabled bytes keep the current field value.
- R5: One cycle after a write, the data field equals the backing register's stored value, including any masking that register applies.
- R6: Changing the index reloads the data field from the newly selected backing register within one cycle.
- R7: When index×4 is at or beyond the file size, no backing write is issued and the data field reads zero after the refresh. The last in-range index works normally.
- R8: Configuration writes outside the two window dwords leave the index, the data field and the backing file unchanged.
- R9: A write with all byte enables low has no effect.
- R10: A data write in the cycle directly after an index change merges against the newly selected register, not the stale copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | DW_W | Dword index of the configuration write |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rd_dw | input | DW_W | Dword index of the configuration read |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| rf_wr_en | output | 1 | Backing register write strobe |
| rf_wr_addr | output | SEL_W+2 | Backing byte address of the write |
| rf_wdata | output | 32 | Backing write data |
| rf_rd_en | output | 1 | Backing read strobe (refresh in progress) |
| rf_rd_addr | output | SEL_W+2 | Backing byte address of the refresh read |
| rf_rdata | input | 32 | Backing read data (combinational) |

## Verification
The stimulus walks the index across three kinds of register: ordinary ones, one whose upper half ignores writes, and out-of-range indexes, both just past and far past the limit. This separates a data path that echoes the written value from one that reloads from the backing file.

Full-dword and single-byte data writes show whether byte merging uses the current copy. An index write followed at once by a partial data write exposes a merge against a stale copy. Writes just below and just above the window, and writes with no byte enables, show that decode and enables gate all state. The backing model returns a non-zero pattern for out-of-range reads, so a missing zero-force is visible.

// File: rtl/iw_pkg.sv
package iw_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_REFRESH = 1'b1
    } iw_state_e;

    localparam int unsigned BYTES_PER_DW = 4;
    localparam int unsigned SEL_LANE     = 2;

endpackage

// File: rtl/iw_decode.sv
module iw_decode #(
    parameter int unsigned DW_W    = 6,
    parameter int unsigned BASE_DW = 16
) (
    input  logic            wr_en,
    input  logic [DW_W-1:0] wr_dw,
    input  logic [3:0]      be,
    input  logic [DW_W-1:0] rd_dw,
    output logic            wr_sel_dw,
    output logic            wr_data_dw,
    output logic            touch,
    output logic            rd_sel_dw,
    output logic            rd_data_dw
);
    localparam logic [DW_W-1:0] SEL_DW  = DW_W'(BASE_DW);
    localparam logic [DW_W-1:0] DATA_DW = DW_W'(BASE_DW + 1);

    logic any_be;

    always_comb begin
        any_be     = |be;
        wr_sel_dw  = wr_en && any_be && (wr_dw == SEL_DW);
        wr_data_dw = wr_en && any_be && (wr_dw == DATA_DW);
        touch      = wr_sel_dw || wr_data_dw;
        rd_sel_dw  = (rd_dw == SEL_DW);
        rd_data_dw = (rd_dw == DATA_DW);
    end
endmodule

// File: rtl/iw_range.sv
module iw_range #(
    parameter int unsigned SEL_W    = 8,
    parameter int unsigned RF_BYTES = 64
) (
    input  logic [SEL_W-1:0] sel,
    output logic [SEL_W+1:0] byte_addr,
    output logic             in_range
);
    always_comb begin
        byte_addr = {sel, 2'b00};
        in_range  = 32'(byte_addr) < 32'(RF_BYTES);
    end
endmodule

// File: rtl/iw_ctrl.sv
module iw_ctrl
    import iw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic touch,
    output logic refreshing
);
    iw_state_e state_q;
    iw_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_REFRESH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:    state_d = touch ? ST_REFRESH : ST_IDLE;
            ST_REFRESH: state_d = touch ? ST_REFRESH : ST_IDLE;
            default:    state_d = ST_REFRESH;
        endcase
    end

    always_comb begin
        refreshing = (state_q == ST_REFRESH);
    end
endmodule

// File: rtl/iw_dword_window.sv
module iw_dword_window
    import iw_pkg::*;
#(
    parameter int unsigned DW_W     = 6,
    parameter int unsigned BASE_DW  = 16,
    parameter int unsigned SEL_W    = 8,
    parameter int unsigned RF_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [DW_W-1:0]  cfg_wr_dw,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    input  logic [DW_W-1:0]  cfg_rd_dw,
    output logic [31:0]      cfg_rdata,
    output logic             rf_wr_en,
    output logic [SEL_W+1:0] rf_wr_addr,
    output logic [31:0]      rf_wdata,
    output logic             rf_rd_en,
    output logic [SEL_W+1:0] rf_rd_addr,
    input  logic [31:0]      rf_rdata
);
    localparam int unsigned SEL_LO = SEL_LANE * 8;
    localparam int unsigned SEL_HI = SEL_LO + SEL_W - 1;

    logic [SEL_W-1:0] sel_q;
    logic [31:0]      data_q;
    logic             wr_sel_dw;
    logic             wr_data_dw;
    logic             touch;
    logic             rd_sel_dw;
    logic             rd_data_dw;
    logic             refreshing;
    logic [SEL_W+1:0] byte_addr;
    logic             in_range;
    logic [31:0]      fresh;
    logic [31:0]      merge_base;
    logic [31:0]      merged;

    iw_decode #(.DW_W(DW_W), .BASE_DW(BASE_DW)) u_decode (
        .wr_en      (cfg_wr_en),
        .wr_dw      (cfg_wr_dw),
        .be         (cfg_be),
        .rd_dw      (cfg_rd_dw),
        .wr_sel_dw  (wr_sel_dw),
        .wr_data_dw (wr_data_dw),
        .touch      (touch),
        .rd_sel_dw  (rd_sel_dw),
        .rd_data_dw (rd_data_dw)
    );

    iw_range #(.SEL_W(SEL_W), .RF_BYTES(RF_BYTES)) u_range (
        .sel       (sel_q),
        .byte_addr (byte_addr),
        .in_range  (in_range)
    );

    iw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .refreshing (refreshing)
    );

    // Out-of-range reads are forced to zero regardless of the file's answer.
    always_comb begin
        fresh      = in_range ? rf_rdata : 32'h0;
        merge_base = refreshing ? fresh : data_q;
    end

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign merged[b*8 +: 8] = cfg_be[b] ? cfg_wdata[b*8 +: 8] : merge_base[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_sel_dw && cfg_be[SEL_LANE]) begin
            sel_q <= cfg_wdata[SEL_HI:SEL_LO];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_data_dw) begin
            data_q <= merged;
        end else if (refreshing) begin
            data_q <= fresh;
        end
    end

    always_comb begin
        rf_wr_en   = wr_data_dw && in_range;
        rf_wr_addr = byte_addr;
        rf_wdata   = merged;
        rf_rd_en   = refreshing;
        rf_rd_addr = byte_addr;
    end

    always_comb begin
        cfg_rdata = 32'h0;
        if (rd_sel_dw) begin
            cfg_rdata[SEL_HI:SEL_LO] = sel_q;
        end else if (rd_data_dw) begin
            cfg_rdata = data_q;
        end
    end
endmodule

// File: rtl/iw_dword_window_chk.sv
module iw_dword_window_chk #(
    parameter int unsigned DW_W     = 6,
    parameter int unsigned BASE_DW  = 16,
    parameter int unsigned SEL_W    = 8,
    parameter int unsigned RF_BYTES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [DW_W-1:0]  cfg_wr_dw,
    input logic [3:0]       cfg_be,
    input logic [DW_W-1:0]  cfg_rd_dw,
    input logic [31:0]      cfg_rdata,
    input logic             rf_wr_en,
    input logic [SEL_W+1:0] rf_wr_addr,
    input logic             rf_rd_en,
    input logic [SEL_W+1:0] rf_rd_addr,
    input logic [31:0]      rf_rdata,
    input logic [SEL_W-1:0] sel_q,
    input logic [31:0]      data_q
);
    localparam logic [DW_W-1:0] C_SEL_DW  = DW_W'(BASE_DW);
    localparam logic [DW_W-1:0] C_DATA_DW = DW_W'(BASE_DW + 1);

    logic        data_hit;
    logic        outside;
    logic        sel_in;
    logic [31:0] exp_fresh;

    always_comb begin
        data_hit  = cfg_wr_en && (|cfg_be) && (cfg_wr_dw == C_DATA_DW);
        outside   = cfg_wr_en && (cfg_wr_dw != C_SEL_DW) && (cfg_wr_dw != C_DATA_DW);
        sel_in    = 32'({sel_q, 2'b00}) < 32'(RF_BYTES);
        exp_fresh = (32'(rf_rd_addr) < 32'(RF_BYTES)) ? rf_rdata : 32'h0;
    end

    // R7
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (32'(rf_wr_addr) < 32'(RF_BYTES)));

    // R3
    fwd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && sel_in) |-> (rf_wr_en && rf_wr_addr == {sel_q, 2'b00}));

    // R9
    no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_be == 4'h0) |-> !rf_wr_en);

    // R8
    outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outside |=> $stable(sel_q));

    // R2
    hdr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_dw == C_SEL_DW) |-> (cfg_rdata[31:24] == 8'h0 && cfg_rdata[15:0] == 16'h0));

    // R5
    refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd_en && !data_hit) |=> (data_q == $past(exp_fresh)));
endmodule

bind iw_dword_window iw_dword_window_chk #(
    .DW_W(DW_W), .BASE_DW(BASE_DW), .SEL_W(SEL_W), .RF_BYTES(RF_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_dw  (cfg_wr_dw),
    .cfg_be     (cfg_be),
    .cfg_rd_dw  (cfg_rd_dw),
    .cfg_rdata  (cfg_rdata),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_addr (rf_wr_addr),
    .rf_rd_en   (rf_rd_en),
    .rf_rd_addr (rf_rd_addr),
    .rf_rdata   (rf_rdata),
    .sel_q      (sel_q),
    .data_q     (data_q)
);

// File: tb/iw_dword_window_tb_top.sv
module iw_dword_window_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    localparam int NWORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_wr_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  cfg_rd_dw = '0;
    logic [31:0] cfg_rdata;
    logic        rf_wr_en;
    logic [9:0]  rf_wr_addr;
    logic [31:0] rf_wdata;
    logic        rf_rd_en;
    logic [9:0]  rf_rd_addr;
    logic [31:0] rf_rdata;
    logic [31:0] mem [NWORDS];

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iw_dword_window dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rd_dw(cfg_rd_dw), .cfg_rdata(cfg_rdata),
        .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wdata(rf_wdata),
        .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rdata(rf_rdata)
    );

    // Backing file model: word 5 keeps its upper half; out-of-range reads give junk.
    function automatic logic [31:0] wmask(int idx);
        return (idx == 5) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    always @(posedge clk) begin
        if (rf_wr_en && int'(rf_wr_addr[9:2]) < NWORDS) begin
            mem[rf_wr_addr[9:2]] <= (mem[rf_wr_addr[9:2]] & ~wmask(int'(rf_wr_addr[9:2])))
                                  | (rf_wdata & wmask(int'(rf_wr_addr[9:2])));
        end
    end

    assign rf_rdata = (int'(rf_rd_addr[9:2]) < NWORDS) ? mem[rf_rd_addr[9:2]] : 32'hDEAD_BEEF;

    // Vector: {wr_dw[7:0], be[3:0], wdata[31:0], rd_dw[7:0], expected[31:0]}
    localparam logic [83:0] VEC [NVEC] = '{
        {8'h11, 4'hF, 32'hA5A5_0001, 8'h11, 32'hA5A5_0001}, // R3 full write
        {8'h10, 4'h4, 32'h0003_0000, 8'h11, 32'h1000_0303}, // R6 select 3
        {8'h10, 4'hF, 32'hFF05_FFFF, 8'h10, 32'h0005_0000}, // R2 status/header zero
        {8'h11, 4'hF, 32'hCAFE_BABE, 8'h11, 32'h1000_BABE}, // R5 masked register
        {8'h11, 4'h2, 32'h0000_7700, 8'h11, 32'h1000_77BE}, // R4 byte merge
        {8'h12, 4'hF, 32'h1234_5678, 8'h11, 32'h1000_77BE}, // R8 above window
        {8'h0F, 4'hF, 32'h1234_5678, 8'h10, 32'h0005_0000}, // R8 below window
        {8'h10, 4'h4, 32'h0020_0000, 8'h11, 32'h0000_0000}, // R7 far out
        {8'h11, 4'hF, 32'h5555_5555, 8'h11, 32'h0000_0000}, // R7 write dropped
        {8'h10, 4'h4, 32'h000F_0000, 8'h11, 32'h1000_0F0F}, // R7 last valid
        {8'h10, 4'h4, 32'h0010_0000, 8'h11, 32'h0000_0000}, // R7 first invalid
        {8'h10, 4'h4, 32'h0000_0000, 8'h11, 32'hA5A5_0001}, // R6 back to 0
        {8'h10, 4'h0, 32'h0007_0000, 8'h10, 32'h0000_0000}  // R9 no enables
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic read_chk(string req, logic [5:0] dw, logic [31:0] exp);
        cfg_rd_dw = dw;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic drive_wr(logic [5:0] dw, logic [3:0] be, logic [31:0] wd);
        cfg_wr_en = 1'b1;
        cfg_wr_dw = dw;
        cfg_be    = be;
        cfg_wdata = wd;
    endtask

    initial begin
        for (int i = 0; i < NWORDS; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h0101;
        repeat (3) @(negedge clk);
        // R1: held in reset
        read_chk("R1", 6'h10, 32'h0);
        check("R1", {31'h0, rf_wr_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk("R1", 6'h11, 32'h1000_0000);
        read_chk("R1", 6'h10, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            drive_wr(VEC[v][77:72], VEC[v][75:72] == 4'h0 ? VEC[v][75:72] : VEC[v][75:72], VEC[v][71:40]);
            cfg_wr_dw = VEC[v][81:76];
            cfg_be    = VEC[v][75:72];
            @(negedge clk);
            cfg_wr_en = 1'b0;
            @(negedge clk);
            read_chk($sformatf("vector %0d", v), VEC[v][37:32], VEC[v][31:0]);
        end

        // R10: index change then immediate partial data write
        @(negedge clk);
        drive_wr(6'h10, 4'h4, 32'h0001_0000);
        @(negedge clk);
        drive_wr(6'h11, 4'h1, 32'h0000_00EE);
        #1;
        check("R10", rf_wdata, 32'h1000_01EE);
        check("R10", {22'h0, rf_wr_addr}, 32'h4);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        @(negedge clk);
        read_chk("R10", 6'h11, 32'h1000_01EE);

        // R3: same-cycle forward
        @(negedge clk);
        drive_wr(6'h11, 4'hF, 32'h600D_CAFE);
        #1;
        check("R3", {31'h0, rf_wr_en}, 32'h1);
        check("R3", {22'h0, rf_wr_addr}, 32'h4);
        check("R3", rf_wdata, 32'h600D_CAFE);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        @(negedge clk);
        read_chk("R5", 6'h11, 32'h600D_CAFE);

        // R7: no strobe for out-of-range data write
        drive_wr(6'h10, 4'h4, 32'h0040_0000);
        @(negedge clk);
        drive_wr(6'h11, 4'hF, 32'h7777_7777);
        #1;
        check("R7", {31'h0, rf_wr_en}, 32'h0);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        @(negedge clk);
        read_chk("R7", 6'h11, 32'h0);

        // R8: word 1 unchanged after outside writes
        drive_wr(6'h10, 4'h4, 32'h0001_0000);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        @(negedge clk);
        read_chk("R8", 6'h11, 32'h600D_CAFE);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule